// File: doc/BRIEF.md
# Complex-Pair Vector Add and Multiply-Accumulate Unit

This block executes complex arithmetic on packed vectors. Each vector is a row of signed fixed-point elements taken two at a time: the lower element of a pair is the real part and the upper element is the imaginary part. The unit runs two operations. The first is a complex add that turns the second operand by 90 or 270 degrees before adding it. The second is a complex multiply-accumulate that adds one of four partial products into an accumulator vector. A full complex multiply therefore takes two issues with rotations 0 and 1, or 2 and 3.

A caller drives the operands and the mode fields and raises `start` for one cycle. The unit captures everything on that edge, processes one complex pair per clock and pulses `done` when all pairs are written. The multiply-accumulate can broadcast one indexed pair of the second operand to every output pair. Elements are 16 or 32 bits wide, and the vector is 64 or 128 bits wide.

Top module: `cplx_simd_unit`

## Requirements
- R1: Element k of a vector sits at bits [k*EW +: EW], where EW is 16 when `esz32`=0 and 32 when `esz32`=1. Pair i is element 2i (real) and element 2i+1 (imaginary). The number of pairs processed is 4 or 2 with `wide`=1 (128-bit), and 2 or 1 with `wide`=0 (64-bit), for 16-bit and 32-bit elements respectively.
- R2: With `op_mla`=0 and `rot[0]`=0 (90 degrees), each output pair is real = a_re - b_im and imag = a_im + b_re. In add mode `rot[1]`, `by_index`, `idx` and `acc_in` have no effect.
- R3: With `op_mla`=0 and `rot[0]`=1 (270 degrees), each output pair is real = a_re + b_im and imag = a_im - b_re.
- R4: With `op_mla`=1 the result is accumulator plus a term. The accumulator pair comes from `acc_in`. For each value of `rot`, the terms added to real and imaginary are: rot=0: a_re*b_re and a_re*b_im. rot=1: -(a_im*b_im) and a_im*b_re. rot=2: -(a_re*b_re) and -(a_re*b_im). rot=3: a_im*b_im and -(a_im*b_re).
- R5: Each product is formed exactly at double width, and negated there if its rotation calls for it. It is then shifted arithmetically right by EW-1, which rounds toward minus infinity. For example, -(1*1) at 16 bits yields -1.
- R6: Every result element saturates to the signed EW range, to 0x7FFF/0x8000 at 16 bits.
- R7: With `op_mla`=1 and `by_index`=1, every output pair uses pair `idx` of the full 128-bit `src_b`: `idx[1:0]` for 16-bit elements, and `idx[0]` alone for 32-bit elements. This holds at either width.
- R8: With `wide`=0, bits [127:64] of `result` are zero when `done` pulses.
- R9: `start` is taken when `busy` is low. `busy` stays high while pairs are written, one per clock. `done` is high for exactly one cycle, right after the N-th clock edge that follows the edge that took `start`, where N is the pair count of R1.
- R10: A `start` raised while `busy` is high is ignored, and the running operation completes with its captured operands.
- R11: After reset `busy`, `done` and `result` are zero. While idle, `result` holds its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch request, taken when not busy |
| op_mla | input | 1 | 0 = rotated add, 1 = multiply-accumulate |
| by_index | input | 1 | Multiply-accumulate takes one broadcast pair of src_b |
| rot | input | 2 | Rotation select |
| idx | input | 2 | Broadcast pair index |
| esz32 | input | 1 | 0 = 16-bit elements, 1 = 32-bit elements |
| wide | input | 1 | 0 = 64-bit vector, 1 = 128-bit vector |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| acc_in | input | 128 | Accumulator vector for multiply-accumulate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Result vector |

## Verification
Operands are captured on the edge that takes `start`. Pair i is written on the (i+1)-th following edge. `done` and the complete `result` appear together after edge N, which is 1, 2 or 4 edges after launch depending on element size and width. Each bench task drives `start` at a falling edge and counts falling edges after the capture edge until `done` is seen. It requires that count to equal N, reads `result` in that same half-cycle, and then checks that `done` has dropped one cycle later. Ignored-start and idle-hold checks sample `result` at falling edges after the inputs have changed, across several cycles.

// File: rtl/cplx_pkg.sv
package cplx_pkg;

  typedef struct packed {
    logic       mla;
    logic       by_index;
    logic [1:0] rot;
    logic [1:0] idx;
    logic       esz32;
    logic       wide;
  } cplx_cmd_t;

endpackage

// File: rtl/cplx_pair_alu.sv
module cplx_pair_alu #(
  parameter int EW = 16
) (
  input  logic                 mla,
  input  logic [1:0]           rot,
  input  logic signed [EW-1:0] a_re,
  input  logic signed [EW-1:0] a_im,
  input  logic signed [EW-1:0] b_re,
  input  logic signed [EW-1:0] b_im,
  input  logic signed [EW-1:0] c_re,
  input  logic signed [EW-1:0] c_im,
  output logic [EW-1:0]        y_re,
  output logic [EW-1:0]        y_im
);
  localparam int PW = 2 * EW;
  localparam int SW = 2 * EW + 2;
  localparam logic signed [SW-1:0] MAXV = {{(SW-EW+1){1'b0}}, {(EW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  logic signed [EW-1:0] mult_x;
  logic signed [PW-1:0] p_bre, p_bim;
  logic signed [SW-1:0] term_re, term_im, sum_re, sum_im;
  logic signed [SW-1:0] ext_are, ext_aim, ext_bre, ext_bim, ext_cre, ext_cim;

  function automatic logic [EW-1:0] clamp(input logic signed [SW-1:0] v);
    if (v > MAXV)      return MAXV[EW-1:0];
    else if (v < MINV) return MINV[EW-1:0];
    else               return v[EW-1:0];
  endfunction

  always_comb begin
    ext_are = SW'(a_re);
    ext_aim = SW'(a_im);
    ext_bre = SW'(b_re);
    ext_bim = SW'(b_im);
    ext_cre = SW'(c_re);
    ext_cim = SW'(c_im);
    // odd rotations multiply the imaginary part of a
    mult_x  = rot[0] ? a_im : a_re;
    p_bre   = mult_x * b_re;
    p_bim   = mult_x * b_im;
    term_re = rot[0] ? SW'(p_bim) : SW'(p_bre);
    term_im = rot[0] ? SW'(p_bre) : SW'(p_bim);
    if (rot[0] ^ rot[1]) term_re = -term_re;
    if (rot[1])          term_im = -term_im;
    term_re = term_re >>> (EW - 1);
    term_im = term_im >>> (EW - 1);
    if (mla) begin
      sum_re = ext_cre + term_re;
      sum_im = ext_cim + term_im;
    end else if (rot[0]) begin
      sum_re = ext_are + ext_bim;
      sum_im = ext_aim - ext_bre;
    end else begin
      sum_re = ext_are - ext_bim;
      sum_im = ext_aim + ext_bre;
    end
    y_re = clamp(sum_re);
    y_im = clamp(sum_im);
  end

endmodule

// File: rtl/cplx_ctrl.sv
module cplx_ctrl #(
  parameter int MAX_PAIRS = 4,
  parameter int CW        = $clog2(MAX_PAIRS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          esz32,
  input  logic          wide,
  output logic          launch,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] pair_idx
);
  logic          busy_q, busy_d, done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d, last_q, last_d;
  logic [1:0]    shift;

  always_comb begin
    launch = start & ~busy_q;
    shift  = {1'b0, esz32} + {1'b0, ~wide};
    last_d = last_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      last_d = CW'((MAX_PAIRS >> shift) - 1);
    end else if (busy_q) begin
      if (cnt_q == last_q) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign pair_idx = cnt_q;

endmodule

// File: rtl/cplx_simd_unit.sv
module cplx_simd_unit
  import cplx_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int EW_S  = 16,
  parameter int EW_L  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_mla,
  input  logic             by_index,
  input  logic [1:0]       rot,
  input  logic [1:0]       idx,
  input  logic             esz32,
  input  logic             wide,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] acc_in,
  output logic             busy,
  output logic             done,
  output logic [VEC_W-1:0] result
);
  localparam int PW_S      = 2 * EW_S;
  localparam int PW_L      = 2 * EW_L;
  localparam int MAX_PAIRS = VEC_W / PW_S;
  localparam int CW        = $clog2(MAX_PAIRS);

  logic             rst_s0, rst_int;
  logic             launch;
  logic [CW-1:0]    pair_idx;
  cplx_cmd_t        cmd_in, cmd_q;
  logic [VEC_W-1:0] a_q, b_q, c_q, res_q, res_d;
  logic [PW_L-1:0]  pair_out [2];
  logic             wide_l, esz32_l;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_int <= rst_s0;
    end
  end

  cplx_ctrl #(.MAX_PAIRS(MAX_PAIRS), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int),
    .start    (start),
    .esz32    (esz32),
    .wide     (wide),
    .launch   (launch),
    .busy     (busy),
    .done     (done),
    .pair_idx (pair_idx)
  );

  always_comb begin
    cmd_in.mla      = op_mla;
    cmd_in.by_index = by_index;
    cmd_in.rot      = rot;
    cmd_in.idx      = idx;
    cmd_in.esz32    = esz32;
    cmd_in.wide     = wide;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) cmd_q <= '0;
    else if (launch) cmd_q <= cmd_in;
  end

  // operand capture: datapath, no reset
  always_ff @(posedge clk) begin
    if (launch) begin
      a_q <= src_a;
      b_q <= src_b;
      c_q <= acc_in;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int EW = (g == 0) ? EW_S : EW_L;
    localparam int PW = 2 * EW;
    localparam int NP = VEC_W / PW;
    localparam int IW = (NP > 1) ? $clog2(NP) : 1;

    logic [IW-1:0]        ai, bi;
    logic signed [EW-1:0] a_re, a_im, b_re, b_im, c_re, c_im;
    logic [EW-1:0]        y_re, y_im;

    assign ai   = IW'(pair_idx);
    assign bi   = (cmd_q.mla && cmd_q.by_index) ? IW'(cmd_q.idx) : ai;
    assign a_re = a_q[ai*PW +: EW];
    assign a_im = a_q[ai*PW+EW +: EW];
    assign b_re = b_q[bi*PW +: EW];
    assign b_im = b_q[bi*PW+EW +: EW];
    assign c_re = c_q[ai*PW +: EW];
    assign c_im = c_q[ai*PW+EW +: EW];

    cplx_pair_alu #(.EW(EW)) u_alu (
      .mla  (cmd_q.mla),
      .rot  (cmd_q.rot),
      .a_re (a_re),
      .a_im (a_im),
      .b_re (b_re),
      .b_im (b_im),
      .c_re (c_re),
      .c_im (c_im),
      .y_re (y_re),
      .y_im (y_im)
    );

    assign pair_out[g] = PW_L'({y_im, y_re});
  end

  always_comb begin
    res_d = res_q;
    if (launch) begin
      res_d = '0;
    end else if (busy) begin
      if (cmd_q.esz32) res_d[pair_idx*PW_L +: PW_L] = pair_out[1];
      else             res_d[pair_idx*PW_S +: PW_S] = pair_out[0][PW_S-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) res_q <= '0;
    else          res_q <= res_d;
  end

  assign result  = res_q;
  assign wide_l  = cmd_q.wide;
  assign esz32_l = cmd_q.esz32;

endmodule

// File: rtl/cplx_chk.sv
module cplx_chk #(
  parameter int VEC_W     = 128,
  parameter int MAX_PAIRS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [VEC_W-1:0] result,
  input logic             wide_l,
  input logic             esz32_l
);
  localparam int CNTW = $clog2(MAX_PAIRS) + 2;

  logic [CNTW-1:0] busy_cnt, exp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               busy_cnt <= '0;
    else if (start && !busy)  busy_cnt <= '0;
    else if (busy)            busy_cnt <= busy_cnt + 1'b1;
  end

  assign exp_cnt = CNTW'(MAX_PAIRS >> ({1'b0, esz32_l} + {1'b0, ~wide_l}));

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                              // R9
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                                   // R9
  AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == exp_cnt));                              // R1
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_l) |-> (result[VEC_W-1:VEC_W/2] == '0));       // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));                       // R11

endmodule

bind cplx_simd_unit cplx_chk #(.VEC_W(VEC_W), .MAX_PAIRS(MAX_PAIRS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .result  (result),
  .wide_l  (wide_l),
  .esz32_l (esz32_l)
);

// File: tb/tb_cplx_simd_unit.sv
module tb_cplx_simd_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, op_mla, by_index, esz32, wide;
  logic [1:0]   rot, idx;
  logic [127:0] src_a, src_b, acc_in;
  logic         busy, done;
  logic [127:0] result;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cplx_simd_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_mla(op_mla), .by_index(by_index),
    .rot(rot), .idx(idx), .esz32(esz32), .wide(wide), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic longint elem(input logic [127:0] v, input int k, input int ew);
    if (ew == 16) return longint'($signed(v[k*16 +: 16]));
    else          return longint'($signed(v[k*32 +: 32]));
  endfunction

  function automatic longint sat(input longint v, input int ew);
    longint mx = (longint'(1) <<< (ew - 1)) - 1;
    longint mn = -(longint'(1) <<< (ew - 1));
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  function automatic int npairs(input bit e32, input bit w);
    return (e32 ? 2 : 4) >> (w ? 0 : 1);
  endfunction

  function automatic logic [127:0] model(input bit mla, input bit bx, input logic [1:0] r,
      input logic [1:0] ix, input bit e32, input bit w,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    logic [127:0] res = '0;
    int ew = e32 ? 32 : 16;
    for (int p = 0; p < npairs(e32, w); p++) begin
      int bp = (mla && bx) ? (e32 ? int'(ix[0]) : int'(ix)) : p;
      longint are = elem(a, 2*p, ew), aim = elem(a, 2*p+1, ew);
      longint bre = elem(b, 2*bp, ew), bim = elem(b, 2*bp+1, ew);
      longint cre = elem(c, 2*p, ew), cim = elem(c, 2*p+1, ew);
      longint re, im, x, tr, ti;
      if (!mla) begin
        re = r[0] ? are + bim : are - bim;
        im = r[0] ? aim - bre : aim + bre;
      end else begin
        x = r[0] ? aim : are;
        case (r)
          2'd0: begin tr =  x*bre; ti =  x*bim; end
          2'd1: begin tr = -x*bim; ti =  x*bre; end
          2'd2: begin tr = -x*bre; ti = -x*bim; end
          default: begin tr = x*bim; ti = -x*bre; end
        endcase
        re = cre + (tr >>> (ew - 1));
        im = cim + (ti >>> (ew - 1));
      end
      re = sat(re, ew);
      im = sat(im, ew);
      if (e32) begin
        res[(2*p)*32 +: 32]   = re[31:0];
        res[(2*p+1)*32 +: 32] = im[31:0];
      end else begin
        res[(2*p)*16 +: 16]   = re[15:0];
        res[(2*p+1)*16 +: 16] = im[15:0];
      end
    end
    return res;
  endfunction

  task automatic drive(input bit mla, input bit bx, input logic [1:0] r, input logic [1:0] ix,
      input bit e32, input bit w, input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    op_mla = mla; by_index = bx; rot = r; idx = ix; esz32 = e32; wide = w;
    src_a = a; src_b = b; acc_in = c;
  endtask

  // launch, measure latency (R9), check done width and result
  task automatic run_op(input string tag, input bit mla, input bit bx, input logic [1:0] r,
      input logic [1:0] ix, input bit e32, input bit w,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
      output logic [127:0] res);
    int n = 0;
    int np = npairs(e32, w);
    logic [127:0] exp = model(mla, bx, r, ix, e32, w, a, b, c);
    @(negedge clk);
    drive(mla, bx, r, ix, e32, w, a, b, c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == np, {tag, " R9 latency"}, 128'(n), 128'(np));
    res = result;
    chk(result == exp, tag, result, exp);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 done one cycle"}, 128'(done), 128'(0));
  endtask

  localparam logic [127:0] VA = 128'h1234_F00D_0400_C000_7A5B_8001_0123_FEDC;
  localparam logic [127:0] VB = 128'h0F0F_8888_3C3C_7FFF_1111_E000_2000_0800;
  localparam logic [127:0] VC = 128'hA5A5_0001_5A5A_FFFF_4000_C000_0100_0010;

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R11 reset flags", {126'd0, busy, done}, 128'd0);
    chk(result == '0, "R11 reset result", result, 128'd0);
  endtask

  task automatic t_add();
    logic [127:0] r0, r1;
    run_op("R2 add90 16b wide", 0, 0, 2'd0, 2'd0, 0, 1, VA, VB, VC, r0);
    run_op("R3 add270 32b wide", 0, 0, 2'd1, 2'd0, 1, 1, VA, VB, VC, r1);
    run_op("R3 add270 16b narrow", 0, 0, 2'd1, 2'd0, 0, 0, VB, VA, VC, r1);
    // rot[1], by_index, idx and accumulator must not matter in add mode
    run_op("R2 add ignores fields", 0, 1, 2'd2, 2'd3, 0, 1, VA, VB, ~VC, r1);
    chk(r1 == r0, "R2 add ignored-field result", r1, r0);
  endtask

  task automatic t_mla();
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      run_op($sformatf("R4 mla16 rot%0d", k), 1, 0, 2'(k), 2'd0, 0, 1, VA, VB, VC, r);
      run_op($sformatf("R4 mla32 rot%0d", k), 1, 0, 2'(k), 2'd0, 1, 1, VB, VA, VC, r);
    end
  endtask

  task automatic t_precision();
    logic [127:0] r;
    // -(1*1) >>> 15 = -1 at 16 bits
    run_op("R5 floor after negate", 1, 0, 2'd2, 2'd0, 0, 0,
           128'h0000_0001, 128'h0000_0001, 128'h0, r);
    chk(r == 128'h0000_FFFF, "R5 explicit value", r, 128'h0000_FFFF);
    // min*min scales to +32768, clamps to 0x7FFF
    run_op("R6 mla product clamp", 1, 0, 2'd0, 2'd0, 0, 0,
           128'h0000_8000, 128'h0000_8000, 128'h0, r);
    chk(r == 128'h0000_7FFF, "R6 mla explicit value", r, 128'h0000_7FFF);
    run_op("R6 add clamp", 0, 0, 2'd0, 2'd0, 0, 0,
           128'h8000_7FFF, 128'h8000_8000, 128'h0, r);
    chk(r == 128'h8000_7FFF, "R6 add explicit value", r, 128'h8000_7FFF);
  endtask

  task automatic t_index();
    logic [127:0] r1, r3;
    run_op("R7 index16 wide idx2", 1, 1, 2'd1, 2'd2, 0, 1, VA, VB, VC, r1);
    run_op("R7 index16 narrow idx3", 1, 1, 2'd3, 2'd3, 0, 0, VA, VB, VC, r1);
    run_op("R7 index32 idx1", 1, 1, 2'd0, 2'd1, 1, 1, VA, VB, VC, r1);
    run_op("R7 index32 idx3", 1, 1, 2'd0, 2'd3, 1, 1, VA, VB, VC, r3);
    chk(r3 == r1, "R7 idx[1] ignored at 32b", r3, r1);
  endtask

  task automatic t_narrow();
    logic [127:0] r;
    run_op("R8 narrow 32b mla", 1, 0, 2'd2, 2'd0, 1, 0, VA, VB, VC, r);
    chk(r[127:64] == '0, "R8 upper half zero", r, {64'd0, r[63:0]});
  endtask

  task automatic t_busy_start();
    logic [127:0] exp = model(1, 0, 2'd1, 2'd0, 0, 1, VA, VB, VC);
    int n = 0;
    bit extra = 0;
    @(negedge clk);
    drive(1, 0, 2'd1, 2'd0, 0, 1, VA, VB, VC);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    n = 1;
    drive(0, 0, 2'd0, 2'd0, 1, 0, ~VA, ~VB, ~VC);
    start = 1'b1;
    @(negedge clk);
    n = 2;
    start = 1'b0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 4, "R10 latency unchanged", 128'(n), 128'd4);
    chk(result == exp, "R10 first op kept", result, exp);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done || busy) extra = 1;
    end
    chk(!extra, "R10 no second run", 128'(extra), 128'd0);
  endtask

  task automatic t_idle();
    logic [127:0] held = result;
    bit moved = 0;
    drive(1, 1, 2'd3, 2'd1, 1, 0, VC, VA, VB);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (result != held) moved = 1;
    end
    chk(!moved, "R11 idle hold", result, held);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    drive(0, 0, 2'd0, 2'd0, 0, 0, '0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_add();
    t_mla();
    t_precision();
    t_index();
    t_narrow();
    t_busy_start();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule